// File: doc/BRIEF.md
# Load/Store Alignment and Lane Unit

This unit sits between a processor's load/store stage and a 64-bit, byte-addressed, little-endian data memory port. A request carries a byte address, a two-bit size code, a store flag, store data and a signed flag. The unit decides whether the access starts on a boundary that is a multiple of its own size. An aligned access is passed to memory in the same cycle, with the address rounded down to a 64-bit word, byte enables for the lanes it touches, and store data moved into those lanes.

Memory returns read data one cycle after an aligned load. The unit moves the addressed bytes down to bit 0 and fills the upper bits with copies of the top loaded bit (signed) or with zeros (unsigned). It raises a load-valid strobe in that same cycle. An access that breaks the alignment rule never reaches memory. It raises a one-cycle fault instead, and it produces no load result.

Top module: `lsu_lane_unit`

## Requirements
- R1: An access is aligned under these rules: size code 0 (1 byte) at any address; code 1 (2 bytes) when address bit 0 is 0; code 2 (4 bytes) when address bits [1:0] are 0; code 3 (8 bytes) when address bits [2:0] are 0. `fault` is high in the cycle after a misaligned request and low in the cycle after an aligned request or an idle cycle.
- R2: A misaligned request drives `mem_en` low and `mem_be` to 0 in its own cycle. It produces no `ld_valid` in the following cycle.
- R3: For an aligned request, `mem_be` bit i is 1 exactly when off <= i < off + 2^size. Here off is address bits [2:0].
- R4: For an aligned store, `mem_en` and `mem_we` are 1 and `mem_wdata` equals `req_wdata` shifted left by 8*off bits. Zeros fill the lanes below off.
- R5: For any aligned request, `mem_en` is 1 and `mem_addr` equals `req_addr` with bits [2:0] cleared. For an aligned load, `mem_we` is 0.
- R6: `ld_valid` is high in the cycle after an aligned load, and only then. In that cycle the low 8*2^size bits of `ld_data` are memory bytes off .. off+2^size-1 of `mem_rdata`, lowest address in the lowest bits.
- R7: With `req_signed` = 1, the bits of `ld_data` above the loaded width copy the top loaded bit.
- R8: With `req_signed` = 0, those upper bits are 0. A size-3 load returns all 64 bits unchanged whatever the flag.
- R9: While `rst_n` is low, and in the first cycle after it rises, `fault` and `ld_valid` are 0.
- R10: An aligned store produces no `ld_valid` and no `fault` in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| req_store | input | 1 | 1 store, 0 load |
| req_signed | input | 1 | Sign-extend load result when 1 |
| req_wdata | input | 64 | Store data, right-justified |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | ADDR_W | Address rounded down to 8 bytes |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Lane-positioned store data |
| mem_rdata | input | 64 | Read data, one cycle after the load strobe |
| fault | output | 1 | Misalignment fault, one cycle after the request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |

## Verification
The memory-side outputs (`mem_en`, `mem_we`, `mem_addr`, `mem_be`, `mem_wdata`) are combinational and due in the request's own cycle. The bench checks them shortly after driving the request on the falling edge. `fault`, `ld_valid` and `ld_data` are due one rising edge later. The bench keeps the prediction for each request pending and compares it at the next falling edge, before it drives the next request. Back-to-back requests therefore overlap without one result hiding another.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned DATA_W = LANES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  // natural alignment: start offset must be a multiple of the size
  function automatic logic size_fits(input acc_size_e sz, input logic [2:0] off);
    case (sz)
      SZ_BYTE: size_fits = 1'b1;
      SZ_HALF: size_fits = (off[0] == 1'b0);
      SZ_WORD: size_fits = (off[1:0] == 2'b00);
      default: size_fits = (off == 3'b000);
    endcase
  endfunction

  // contiguous lane run of 2^sz lanes starting at off
  function automatic logic [LANES-1:0] lane_run(input acc_size_e sz, input logic [2:0] off);
    logic [LANES:0] base;
    base = ({{LANES{1'b0}}, 1'b1} << (4'd1 << sz)) - 1'b1;
    lane_run = base[LANES-1:0] << off;
  endfunction

  // width adjust of a right-justified load value
  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] raw,
                                              input acc_size_e sz, input logic sgn);
    case (sz)
      SZ_BYTE: widen = {{(DATA_W-8){sgn & raw[7]}},   raw[7:0]};
      SZ_HALF: widen = {{(DATA_W-16){sgn & raw[15]}}, raw[15:0]};
      SZ_WORD: widen = {{(DATA_W-32){sgn & raw[31]}}, raw[31:0]};
      default: widen = raw;
    endcase
  endfunction
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_lane_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  acc_size_e size,
  input  logic [2:0] off,
  output logic      go,
  output logic      misalign
);
  logic fits;
  assign fits     = size_fits(size, off);
  assign go       = req_valid & fits;
  assign misalign = req_valid & ~fits;

  // R1
  misalign_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (off != 3'b000 && size != SZ_BYTE));
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  acc_size_e         size,
  input  logic [2:0]        off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_lane
);
  assign be         = en ? lane_run(size, off) : '0;
  assign wdata_lane = wdata << {off, 3'b000};

  // R3
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(be) == (32'd1 << size)));
  // R3
  lane_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> be[off]);
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
  import lsu_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  acc_size_e         size,
  input  logic [2:0]        off,
  input  logic              sgn,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  logic       vld_q;
  acc_size_e  sz_q;
  logic [2:0] off_q;
  logic       sgn_q;
  logic [DATA_W-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sz_q  <= SZ_BYTE;
      off_q <= '0;
      sgn_q <= 1'b0;
    end else begin
      vld_q <= capture;
      if (capture) begin
        sz_q  <= size;
        off_q <= off;
        sgn_q <= sgn;
      end
    end
  end

  assign shifted  = rdata >> {off_q, 3'b000};
  assign ld_data  = widen(shifted, sz_q, sgn_q);
  assign ld_valid = vld_q;

  // R6
  load_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(capture));
  // R8
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !sgn_q && sz_q == SZ_BYTE) |-> (ld_data[DATA_W-1:8] == '0));
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_store,
  input  logic              req_signed,
  input  logic [63:0]       req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              fault,
  output logic              ld_valid,
  output logic [63:0]       ld_data
);
  localparam int unsigned OFF_W = $clog2(LANES);

  acc_size_e        size_e;
  logic [OFF_W-1:0] off;
  logic             align_go;
  logic             misalign;
  logic             load_go;
  logic             fault_q;

  assign size_e = acc_size_e'(req_size);
  assign off    = req_addr[OFF_W-1:0];

  lsu_align_check u_align (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .size(size_e), .off(off),
    .go(align_go), .misalign(misalign)
  );

  lsu_store_lanes u_lanes (
    .clk(clk), .rst_n(rst_n), .en(align_go), .size(size_e), .off(off),
    .wdata(req_wdata), .be(mem_be), .wdata_lane(mem_wdata)
  );

  assign load_go = align_go & ~req_store;

  lsu_load_extend u_load (
    .clk(clk), .rst_n(rst_n), .capture(load_go), .size(size_e), .off(off),
    .sgn(req_signed), .rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  assign mem_en   = align_go;
  assign mem_we   = align_go & req_store;
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= misalign;
  end
  assign fault = fault_q;

  // R2
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_en && mem_be == 8'h00));
  // R1
  fault_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid));
  // R2
  fault_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !ld_valid);
  // R10
  store_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> !ld_valid);
endmodule

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_store = 1'b0;
  logic        req_signed = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        fault, ld_valid;
  logic [63:0] ld_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lsu_lane_unit #(.ADDR_W(32)) i_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .req_signed(req_signed),
    .req_wdata(req_wdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fault(fault), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // memory model: 32 words, one-cycle read latency
  logic [63:0] mdl [0:31];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int j = 0; j < 8; j++)
          if (mem_be[j]) mdl[mem_addr[7:3]][j*8 +: 8] <= mem_wdata[j*8 +: 8];
      end else begin
        mem_rdata <= mdl[mem_addr[7:3]];
      end
    end
  end

  // byte-level reference memory
  logic [7:0] ref_mem [0:255];

  // prediction for the outstanding request
  bit          p_fault, p_ldv;
  logic [63:0] p_data;
  string       p_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_pending();
    chk(fault == p_fault, p_fault ? "R1" : "R10", {"fault ", p_tag}, 64'(fault), 64'(p_fault));
    chk(ld_valid == p_ldv, p_ldv ? "R6" : "R2", {"ld_valid ", p_tag}, 64'(ld_valid), 64'(p_ldv));
    if (p_ldv)
      chk(ld_data == p_data, "R7/R8 data", p_tag, ld_data, p_data);
  endtask

  task automatic issue(input bit v, input logic [7:0] a, input logic [1:0] sz,
                       input bit st, input bit sg, input logic [63:0] wd);
    int n, off;
    bit ok;
    logic [7:0] exp_be;
    logic [63:0] exp_wd, exp_ld;
    @(negedge clk);
    check_pending();
    req_valid = v; req_addr = {24'h0, a}; req_size = sz;
    req_store = st; req_signed = sg; req_wdata = wd;
    #1;
    n   = 1 << sz;
    off = a % 8;
    ok  = (a % n) == 0;
    exp_be = '0; exp_wd = '0;
    for (int j = 0; j < 8; j++) begin
      if (j >= off && j < off + n) exp_be[j] = 1'b1;
      if (j >= off) exp_wd[j*8 +: 8] = wd[(j-off)*8 +: 8];
    end
    p_tag = $sformatf("addr=%0d size=%0d st=%0d sg=%0d", a, sz, st, sg);
    if (v && !ok) begin
      chk(!mem_en, "R2", {"mem_en ", p_tag}, 64'(mem_en), 64'd0);
      chk(mem_be == 8'h00, "R2", {"mem_be ", p_tag}, 64'(mem_be), 64'd0);
    end else if (v) begin
      chk(mem_en && mem_we == st, "R5", {"en/we ", p_tag}, {mem_en, mem_we}, {1'b1, st});
      chk(mem_addr == {24'h0, a[7:3], 3'b000}, "R5", {"mem_addr ", p_tag},
          64'(mem_addr), 64'({a[7:3], 3'b000}));
      chk(mem_be == exp_be, "R3", {"mem_be ", p_tag}, 64'(mem_be), 64'(exp_be));
      if (st) chk(mem_wdata == exp_wd, "R4", {"mem_wdata ", p_tag}, mem_wdata, exp_wd);
    end else begin
      chk(!mem_en, "R2", "mem_en idle", 64'(mem_en), 64'd0);
    end
    exp_ld = '0;
    for (int j = 0; j < 8; j++) begin
      if (j < n) exp_ld[j*8 +: 8] = ref_mem[(a + j) % 256];
      else       exp_ld[j*8 +: 8] = (sg && exp_ld[n*8-1]) ? 8'hff : 8'h00;
    end
    if (v && ok && st)
      for (int j = 0; j < n; j++) ref_mem[(a + j) % 256] = wd[j*8 +: 8];
    p_fault = v && !ok;
    p_ldv   = v && ok && !st;
    p_data  = exp_ld;
  endtask

  initial begin
    for (int w = 0; w < 32; w++)
      for (int j = 0; j < 8; j++) begin
        mdl[w][j*8 +: 8] = 8'((w*8 + j) * 37 + 5);
        ref_mem[w*8 + j] = 8'((w*8 + j) * 37 + 5);
      end
    p_fault = 0; p_ldv = 0; p_data = '0; p_tag = "reset";
    repeat (3) @(negedge clk);
    chk(fault == 0 && ld_valid == 0, "R9", "outputs in reset", {fault, ld_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fault == 0 && ld_valid == 0, "R9", "after reset", {fault, ld_valid}, 0);
    // every size at every offset: store, then signed and unsigned loads
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 8; o++) begin
        issue(1, 8'(64 + o), 2'(sz), 1, 0, 64'h8F9E_ADBC_CBDA_E9F8 ^ 64'(sz*8+o));
        issue(1, 8'(64 + o), 2'(sz), 0, 1, '0);
        issue(1, 8'(64 + o), 2'(sz), 0, 0, '0);
      end
    // loads of the initial pattern, both extensions, all alignments
    for (int a = 0; a < 24; a++)
      for (int sz = 0; sz < 4; sz++) begin
        issue(1, 8'(128 + a), 2'(sz), 0, 1, '0);
        issue(1, 8'(128 + a), 2'(sz), 0, 0, '0);
      end
    issue(0, 8'd3, 2'd3, 0, 0, '0);
    // random mix with idle gaps
    for (int k = 0; k < 400; k++)
      issue(($urandom % 5) != 0, 8'($urandom), 2'($urandom), 1'($urandom),
            1'($urandom), {$urandom, $urandom});
    issue(0, 0, 0, 0, 0, '0);
    issue(0, 0, 0, 0, 0, '0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule